// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block decides whether a short relative branch is taken and produces the address to continue from. Each request carries the four condition flags left by an earlier instruction, a 5-bit condition select, an 8-bit signed displacement counted in 16-bit words, and the already-advanced program counter. The block returns a taken flag and a 16-bit continuation address. When the branch is taken, that address is the program counter plus twice the sign-extended displacement. Otherwise it is the program counter unchanged.

Requests enter and results leave on valid/ready streams. A request moves when `in_valid` and `in_ready` are both high on a rising clock edge. A result moves when `out_valid` and `out_ready` are both high on a rising clock edge. Parameter `REG_OUT` picks the output variant:

- With `REG_OUT=1` (the default), there is a single registered stage, so a result appears one cycle after its request is accepted.
- A stalled result holds steady until it is taken.
- `in_ready` is high when the stage is empty or its result is leaving in the same cycle.
- With `REG_OUT=0` the block is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Top module: `br_eval`

## Requirements
- R1: Flag word bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. The simple select codes are:
  - 2 is taken when Z=0 and 3 when Z=1.
  - 4 is taken when N=1 and 5 when N=0.
  - 6 is taken when V=0 and 7 when V=1.
  - 8 is taken when C=0 and 9 when C=1.
- R2: Select code 1 is always taken and select code 0 is never taken, whatever the flags.
- R3: Signed codes: 10 is taken when N xor V is 0, 11 when N xor V is 1, 12 when Z or (N xor V) is 0, and 13 when Z or (N xor V) is 1.
- R4: Unsigned codes: 14 is taken when C=0 and Z=0, 15 when C=1 or Z=1, 16 when C=0, and 17 when C=1.
- R5: Select codes 18 to 31 are never taken.
- R6: For a taken branch, the result address is the program counter plus two times the sign-extended displacement, modulo 2^16. The reach is therefore -128 to +127 words.
- R7: For a branch that is not taken, the result address equals the program counter.
- R8: Results leave in request order, one per accepted request. While `out_valid` is high and `out_ready` is low, the taken flag and the address stay unchanged.
- R9: While reset is asserted and on the cycle after it, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_cc | input | 4 | Flags {N,Z,V,C} |
| in_sel | input | 5 | Condition select code |
| in_disp | input | 8 | Signed word displacement |
| in_pc | input | 16 | Advanced program counter |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts result |
| out_taken | output | 1 | Branch taken |
| out_target | output | 16 | Continuation address |

## Verification
The hardest case to reach from the ports is a result held under back-pressure while the next request is already waiting at the input, because the hold and the refill of the register must not lose or reorder items. A second full sweep of every flag and select combination runs while a pseudo-random sequence drops `out_ready`, so stalls fall on arbitrary items. The address wrap around zero is reached with a program counter near either end of the range combined with the extreme displacements.

// File: rtl/br_eval_pkg.sv
package br_eval_pkg;
  localparam int SEL_W = 5;
  localparam int CC_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    BC_NEVER  = 5'd0,
    BC_ALWAYS = 5'd1,
    BC_NE     = 5'd2,
    BC_EQ     = 5'd3,
    BC_MI     = 5'd4,
    BC_PL     = 5'd5,
    BC_VC     = 5'd6,
    BC_VS     = 5'd7,
    BC_CC     = 5'd8,
    BC_CS     = 5'd9,
    BC_GE     = 5'd10,
    BC_LT     = 5'd11,
    BC_GT     = 5'd12,
    BC_LE     = 5'd13,
    BC_HI     = 5'd14,
    BC_LOS    = 5'd15,
    BC_HIS    = 5'd16,
    BC_LO     = 5'd17
  } br_cond_e;

  localparam int COND_COUNT = 18;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/br_cond_decode.sv
module br_cond_decode
  import br_eval_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [CC_W-1:0]  cc,
  output logic             taken
);
  cc_t f;
  logic sgn_lt;

  always_comb begin
    f      = cc_t'(cc);
    sgn_lt = f.n ^ f.v;
    case (sel)
      BC_ALWAYS: taken = 1'b1;
      BC_NE:     taken = ~f.z;
      BC_EQ:     taken = f.z;
      BC_MI:     taken = f.n;
      BC_PL:     taken = ~f.n;
      BC_VC:     taken = ~f.v;
      BC_VS:     taken = f.v;
      BC_CC:     taken = ~f.c;
      BC_CS:     taken = f.c;
      BC_GE:     taken = ~sgn_lt;
      BC_LT:     taken = sgn_lt;
      BC_GT:     taken = ~(f.z | sgn_lt);
      BC_LE:     taken = f.z | sgn_lt;
      BC_HI:     taken = ~(f.c | f.z);
      BC_LOS:    taken = f.c | f.z;
      BC_HIS:    taken = ~f.c;
      BC_LO:     taken = f.c;
      default:   taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic              taken,
  output logic [PC_W-1:0]   target
);
  localparam int EXT_W = PC_W - DISP_W - 1;

  logic [PC_W-1:0] byte_off;

  always_comb begin
    byte_off = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
    target   = taken ? (pc + byte_off) : pc;
  end
endmodule

// File: rtl/br_out_stage.sv
module br_out_stage #(
  parameter int W       = 17,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         valid_q;
      logic [W-1:0] data_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
        end else if (in_ready) begin
          valid_q <= in_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (in_ready && in_valid) data_q <= in_data;
      end

      assign in_ready  = ~valid_q | out_ready;
      assign out_valid = valid_q;
      assign out_data  = data_q;

      assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/br_eval.sv
module br_eval
  import br_eval_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int DISP_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_cc,
  input  logic [4:0]        in_sel,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [PC_W-1:0]   in_pc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_target
);
  localparam int RES_W = PC_W + 1;

  logic             dec_taken;
  logic [PC_W-1:0]  calc_target;
  logic [RES_W-1:0] res_out;

  br_cond_decode u_dec (
    .sel   (in_sel),
    .cc    (in_cc),
    .taken (dec_taken)
  );

  br_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .pc     (in_pc),
    .disp   (in_disp),
    .taken  (dec_taken),
    .target (calc_target)
  );

  br_out_stage #(.W(RES_W), .REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({dec_taken, calc_target}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_out)
  );

  assign out_taken  = res_out[PC_W];
  assign out_target = res_out[PC_W-1:0];

  assert_always_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel == BC_ALWAYS) |-> dec_taken);

  assert_signed_ge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel == BC_GE) |-> (dec_taken == (in_cc[3] == in_cc[1])));

  assert_unsigned_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel == BC_HI && in_cc[0]) |-> !dec_taken);

  assert_unused_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sel >= COND_COUNT[4:0]) |-> !dec_taken);

  assert_fallthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_taken) |-> (calc_target == in_pc));
endmodule

// File: tb/br_eval_test.sv
module br_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_cc = '0;
  logic [4:0]  in_sel = '0;
  logic [7:0]  in_disp = '0;
  logic [15:0] in_pc = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_taken;
  logic [15:0] out_target;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit stall_mode = 1'b0;
  logic [16:0] exp_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  br_eval uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_cc(in_cc), .in_sel(in_sel), .in_disp(in_disp), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_target(out_target)
  );

  function automatic logic exp_taken(input int s, input logic [3:0] f);
    logic n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (s)
      1:  return 1'b1;
      2:  return !z;
      3:  return z;
      4:  return n;
      5:  return !n;
      6:  return !v;
      7:  return v;
      8:  return !c;
      9:  return c;
      10: return n == v;
      11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      14: return !c && !z;
      15: return c || z;
      16: return !c;
      17: return c;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int s);
    if (s <= 1) return "R2";
    if (s <= 9) return "R1";
    if (s <= 13) return "R3";
    if (s <= 17) return "R4";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input int s, input logic [3:0] f, input logic [7:0] d, input logic [15:0] pc);
    logic t;
    logic [15:0] tg;
    logic [15:0] off;
    t   = exp_taken(s, f);
    off = {{7{d[7]}}, d, 1'b0};
    tg  = t ? pc + off : pc;
    in_valid = 1'b1;
    in_sel = s[4:0]; in_cc = f; in_disp = d; in_pc = pc;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    exp_q.push_back({t, tg});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // out_ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= stall_mode ? lfsr[0] | lfsr[3] : 1'b1;
  end

  // monitor / scoreboard
  logic        prev_stall = 1'b0;
  logic [16:0] prev_out;
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (prev_stall) begin
          // R8: a stalled result is held
          check(out_valid && {out_taken, out_target} == prev_out, "R8 hold",
                {out_taken, out_target}, prev_out);
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 extra result", {out_taken, out_target}, 17'h0);
          end else begin
            logic [16:0] e;
            e = exp_q.pop_front();
            // R6/R7 address, R1-R5 taken flag via scoreboard
            check({out_taken, out_target} == e, e[16] ? "R6 taken item" : "R7 fallthrough item",
                  {out_taken, out_target}, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_out   = {out_taken, out_target};
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: no result during reset
    check(out_valid == 1'b0, "R9 reset", {16'h0, out_valid}, 17'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R9 after reset", {16'h0, out_valid}, 17'h0);
    @(negedge clk);

    // Sweep every select and flag combination, R1 R2 R3 R4 R5
    for (int s = 0; s < 32; s++) begin
      for (int f = 0; f < 16; f++) begin
        send(s, f[3:0], 8'(s * 16 + f), 16'(16'h4000 + s * 64 + f * 2));
      end
    end

    // R6 wrap and reach extremes
    send(1, 4'h0, 8'h80, 16'h0000);   // -> FF00
    send(1, 4'h0, 8'h7F, 16'hFFFE);   // -> 00FC
    send(1, 4'h0, 8'hFF, 16'h0000);   // -> FFFE
    send(0, 4'hF, 8'h7F, 16'h1234);   // R7: never taken keeps pc

    // Second sweep under back-pressure, R8
    stall_mode = 1'b1;
    for (int s = 0; s < 32; s++) begin
      for (int f = 0; f < 16; f++) begin
        send(s, f[3:0], 8'(255 - s * 8 - f), 16'(16'hFF00 + f * 30 + s));
      end
    end
    stall_mode = 1'b0;

    repeat (20) @(negedge clk);
    // R8: every request produced exactly one result
    check(exp_q.size() == 0, "R8 drained", 17'(exp_q.size()), 17'h0);
    finish_run();
  end
endmodule